// File: doc/BRIEF.md
# Periodic Training Insertion Scheduler

This block tells a packet-interface data transmitter when to replace its data stream with training patterns. An interval timer counts qualified data-path cycles. Each time it expires, it schedules a burst of back-to-back training sequences. The burst length and the timer period are both configuration inputs. A period of zero switches the periodic schedule off. A burst length of zero also yields no insertions.

A periodic burst never cuts into a data transfer. The scheduler holds the burst back until the transmitter reports an allowed boundary. Once the burst has started, `train_req` stays high until the pattern generator has reported the required number of finished sequences. A forced-training input comes from the status synchronization monitor and takes precedence over everything else. While it is asserted, `train_req` is held high. Every finished sequence seen while training is requested is echoed on `seq_mark`.

The control is a four-state machine:
- `S_IDLE`: waiting.
- `S_PEND`: a periodic burst is due and is waiting for a boundary.
- `S_BURST`: a periodic burst is being counted.
- `S_FORCED`: synchronization training.

The transitions are:
- IDLE→PEND: timer expiry with a nonzero burst length.
- PEND→BURST: boundary seen.
- BURST→IDLE: the last sequence is finished.
- any→FORCED: force asserted.
- FORCED→IDLE: force released.

Top module: `train_sched`

## Requirements
- R1: After reset, `train_req` and `seq_mark` are 0 and the interval timer restarts from zero.
- R2: The timer advances only on cycles where `data_cycle` is 1. It expires once every `interval_cfg` such cycles.
- R3: With `interval_cfg` = 0 the timer never expires, and no periodic training is requested.
- R4: With `reps_cfg` = 0, an expiry of the timer causes no training request.
- R5: Each accepted expiry makes `train_req` rise and stay 1 until exactly `reps_cfg` pulses of `seq_done` have been seen. `train_req` falls on the clock edge that samples the last of those pulses.
- R6: A due periodic burst waits while `burst_boundary` is 0. `train_req` rises on the edge that samples `burst_boundary` = 1.
- R7: `train_req` is 1 starting from the edge that samples `force_train` = 1, from any state, and stays 1 while the input is held. It drops on the edge that samples it at 0. A periodic burst in progress is abandoned.
- R8: `seq_mark` is 1 for one cycle, one edge after a `seq_done` pulse that was sampled while `train_req` was 1. A `seq_done` pulse sampled with `train_req` at 0 has no effect.
- R9: Timer expiries that occur while the machine is not in `S_IDLE` are discarded and are not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_cycle | input | 1 | Qualifies a data-path cycle for the interval timer |
| interval_cfg | input | 16 | Timer period in data cycles; 0 disables periodic training |
| reps_cfg | input | 8 | Training sequences per periodic burst |
| force_train | input | 1 | Continuous training request from the sync monitor |
| burst_boundary | input | 1 | High when a periodic burst may begin |
| seq_done | input | 1 | Pulse from the pattern generator per finished sequence |
| train_req | output | 1 | Training request to the pattern generator |
| seq_mark | output | 1 | One-cycle strobe per finished sequence |

## Verification
All outputs are registered, and every result appears one edge after the input that causes it. A timer expiry reaches `train_req` two edges later: one edge to enter PEND and one to enter BURST when a boundary is present. The bench drives inputs just after an edge and samples 1 ns after the next rising edge. Direct checks are therefore made on the first sample following the decisive edge. The sweeps count request and strobe cycles over whole runs, with a drain period long enough for the last burst to finish. The expected totals are the product of expiries and burst length.

// File: rtl/train_sched_pkg.sv
package train_sched_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_PEND   = 2'd1,
        S_BURST  = 2'd2,
        S_FORCED = 2'd3
    } sched_state_t;
endpackage

// File: rtl/train_interval_timer.sv
module train_interval_timer #(
    parameter int INT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_cycle,
    input  logic [INT_W-1:0] interval,
    output logic             tick
);
    localparam logic [INT_W-1:0] ONE = INT_W'(1);

    logic [INT_W-1:0] cnt;
    logic             enabled;
    logic             at_end;

    assign enabled = (interval != '0);
    assign at_end  = enabled && (cnt >= interval - ONE);
    assign tick    = data_cycle && at_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!enabled) begin
            cnt <= '0;
        end else if (data_cycle) begin
            if (at_end) cnt <= '0;
            else        cnt <= cnt + ONE;
        end
    end

    // R3
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (interval == '0) |=> (cnt == '0));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_cycle && enabled && $stable(interval)) |=> $stable(cnt));
endmodule

// File: rtl/train_rep_counter.sv
module train_rep_counter #(
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REP_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    localparam logic [REP_W-1:0] ONE = REP_W'(1);

    logic [REP_W-1:0] remaining;

    assign last = (remaining == ONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_val;
        end else if (dec && remaining != '0) begin
            remaining <= remaining - ONE;
        end
    end

    // R4
    load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));
endmodule

// File: rtl/train_sched.sv
module train_sched
    import train_sched_pkg::*;
#(
    parameter int INT_W = 16,
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_cycle,
    input  logic [INT_W-1:0] interval_cfg,
    input  logic [REP_W-1:0] reps_cfg,
    input  logic             force_train,
    input  logic             burst_boundary,
    input  logic             seq_done,
    output logic             train_req,
    output logic             seq_mark
);
    sched_state_t state, nxt;
    logic tick, last, load, busy;

    train_interval_timer #(.INT_W(INT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_cycle (data_cycle),
        .interval   (interval_cfg),
        .tick       (tick)
    );

    train_rep_counter #(.REP_W(REP_W)) u_reps (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (reps_cfg),
        .dec      (seq_done && state == S_BURST),
        .last     (last)
    );

    assign busy = (state == S_BURST) || (state == S_FORCED);

    always_comb begin
        nxt  = state;
        load = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (force_train)                    nxt = S_FORCED;
                else if (tick && reps_cfg != '0)    nxt = S_PEND;
            end
            S_PEND: begin
                if (force_train) begin
                    nxt = S_FORCED;
                end else if (burst_boundary && reps_cfg != '0) begin
                    nxt  = S_BURST;
                    load = 1'b1;
                end else if (reps_cfg == '0) begin
                    nxt = S_IDLE;
                end
            end
            S_BURST: begin
                if (force_train)            nxt = S_FORCED;
                else if (seq_done && last)  nxt = S_IDLE;
            end
            S_FORCED: begin
                if (!force_train)           nxt = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            train_req <= 1'b0;
            seq_mark  <= 1'b0;
        end else begin
            train_req <= (nxt == S_BURST) || (nxt == S_FORCED);
            seq_mark  <= seq_done && busy;
        end
    end

    // R7
    force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_train |=> train_req);

    // R7
    force_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FORCED && !force_train) |=> !train_req);

    // R8
    mark_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_done || !train_req) |=> !seq_mark);

    // R6
    pend_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PEND && !burst_boundary && !force_train && reps_cfg != '0)
            |=> (state == S_PEND && !train_req));
endmodule

// File: tb/tb_train_sched.sv
`timescale 1ns/1ps
module tb_train_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        data_cycle = 1'b0;
    logic [15:0] interval_cfg = '0;
    logic [7:0]  reps_cfg = '0;
    logic        force_train = 1'b0;
    logic        burst_boundary = 1'b0;
    logic        seq_done = 1'b0;
    logic        train_req, seq_mark;

    int tests = 0, fails = 0;
    int req_cnt = 0, mark_cnt = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    train_sched dut (
        .clk(clk), .rst_n(rst_n), .data_cycle(data_cycle),
        .interval_cfg(interval_cfg), .reps_cfg(reps_cfg),
        .force_train(force_train), .burst_boundary(burst_boundary),
        .seq_done(seq_done), .train_req(train_req), .seq_mark(seq_mark)
    );

    task automatic step();
        @(posedge clk);
        #1;
        if (train_req) req_cnt++;
        if (seq_mark)  mark_cnt++;
    endtask

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        data_cycle = 0; force_train = 0; burst_boundary = 0; seq_done = 0;
        rst_n = 0;
        step(); step();
        rst_n = 1;
        req_cnt = 0; mark_cnt = 0;
    endtask

    initial begin
        // R1: outputs are low in reset
        rst_n = 0;
        step(); step();
        check("R1 req", train_req, 0);
        check("R1 mark", seq_mark, 0);

        // Sweep over burst length and period (R2 R3 R4 R5)
        for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < 3; k++) begin
                int iv, expt, ncyc;
                iv = (k == 0) ? 0 : ((k == 1) ? r + 3 : r + 5);
                interval_cfg = 16'(iv); reps_cfg = 8'(r);
                do_reset();
                data_cycle = 1; burst_boundary = 1; seq_done = 1;
                ncyc = (iv == 0) ? 20 : iv * 4;
                for (int c = 0; c < ncyc; c++) step();
                data_cycle = 0;
                for (int c = 0; c < 8; c++) step();
                expt = (iv == 0) ? 0 : 4 * r;
                check((iv == 0) ? "R3 req cycles" : (r == 0 ? "R4 req cycles" : "R5 req cycles"), req_cnt, expt);
                check("R8 mark count", mark_cnt, expt);
            end
        end

        // R2: only qualified cycles advance the timer
        interval_cfg = 16'd2; reps_cfg = 8'd1;
        do_reset();
        burst_boundary = 1; seq_done = 1;
        for (int c = 0; c < 8; c++) begin
            data_cycle = (c % 2 == 0);
            step();
        end
        data_cycle = 0;
        for (int c = 0; c < 6; c++) step();
        check("R2 gated expiries", req_cnt, 2);

        // R2: no qualified cycles, no training
        do_reset();
        burst_boundary = 1;
        for (int c = 0; c < 20; c++) step();
        check("R2 no data cycles", req_cnt, 0);

        // R6: boundary wait
        interval_cfg = 16'd3; reps_cfg = 8'd1;
        do_reset();
        data_cycle = 1;
        for (int c = 0; c < 3; c++) step();
        data_cycle = 0;
        for (int c = 0; c < 5; c++) step();
        check("R6 held while no boundary", req_cnt, 0);
        burst_boundary = 1;
        step();
        check("R6 rises at boundary", train_req, 1);
        burst_boundary = 0;

        // R5 and R9: counted completion, no queued expiries
        interval_cfg = 16'd2; reps_cfg = 8'd3;
        do_reset();
        data_cycle = 1; burst_boundary = 1;
        for (int c = 0; c < 20; c++) step();
        data_cycle = 0;
        check("R5 held without done", train_req, 1);
        seq_done = 1; step(); seq_done = 0; step();
        seq_done = 1; step(); seq_done = 0; step();
        check("R5 still high after two", train_req, 1);
        seq_done = 1; step(); seq_done = 0;
        check("R5 falls on last done", train_req, 0);
        req_cnt = 0;
        for (int c = 0; c < 10; c++) step();
        check("R9 no queued burst", req_cnt, 0);

        // R7: forced training
        interval_cfg = 16'd0; reps_cfg = 8'd2;
        do_reset();
        force_train = 1;
        step();
        check("R7 rises", train_req, 1);
        for (int c = 0; c < 10; c++) step();
        check("R7 held", req_cnt, 11);
        seq_done = 1; step(); seq_done = 0;
        check("R8 mark in forced", seq_mark, 1);
        step();
        check("R8 mark one cycle", seq_mark, 0);
        force_train = 0;
        step();
        check("R7 falls", train_req, 0);

        // R8: done ignored when idle
        mark_cnt = 0;
        seq_done = 1;
        for (int c = 0; c < 5; c++) step();
        seq_done = 0;
        check("R8 ignored done", mark_cnt, 0);

        // R7: force abandons a periodic burst
        interval_cfg = 16'd2; reps_cfg = 8'd3;
        do_reset();
        data_cycle = 1; burst_boundary = 1;
        for (int c = 0; c < 4; c++) step();
        data_cycle = 0;
        force_train = 1; step(); force_train = 0; step();
        check("R7 burst abandoned", train_req, 0);

        done_flag = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done_flag) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule